// File: doc/BRIEF.md
# Power Domain Command Controller

This block is the register-mapped power controller of a compute engine with five power domains. The domains are the L2 cache, the tiler, the shader array, the base logic and the stack logic. Each domain holds a small set of cores. The host first writes a 64-bit argument register, usually a core mask. It then writes a command word. Writing the command word is the only trigger, and the command uses whatever argument is already latched.

The block powers cores up or down after a parameterised settling delay. It hands a domain's ownership to an on-chip microcontroller (delegate) and takes it back (retract). It can perform a soft reset. It checks every command and rejects the malformed ones and the forbidden ones.

Software reads the following back:
- a present mask, a ready mask and an in-transition mask for each domain;
- a status word with ownership flags;
- an eight-source interrupt block made of a raw register, a mask register and a write-one-to-clear register.

One sequencer runs one timed operation at a time.

Top module: `pwr_domain_ctrl`

## Requirements
- R1: After reset every ready and in-transition mask reads 0. The status word reads 0x1F, which means every allow flag (status bits 4:0, one per domain code) is set and every delegated flag (status bits 12:8) is clear. The raw and mask interrupt registers read 0 and `irq` is low.
- R2: Register word addresses are as follows. The argument is at 0x00 and the command at 0x01. The status is at 0x02, the raw interrupts at 0x03, the interrupt mask at 0x04, the clear register at 0x05 and the masked interrupts at 0x06. The masks of domain d are at 0x10+4d: present at +0, ready at +1, in-transition at +2. When a power-up (opcode 1) or power-down (opcode 2) is written at clock edge E, the in-transition mask shows the affected cores from edge E up to edge E+SETTLE. At edge E+SETTLE those ready bits become 1 (up) or 0 (down), and the in-transition mask returns to 0.
- R3: Argument bits outside the target domain's present mask have no effect. A ready bit is never set for a core that is not present.
- R4: The command word holds the opcode in bits 3:0, the domain in bits 6:4 and the subdomain in bits 11:8. Domain codes are: L2 0, tiler 1, shader 2, base 3, stack 4. Any of the following raises command-invalid (interrupt bit 7) and changes nothing: an opcode outside 1 to 6, a domain code above 4, or a nonzero subdomain other than the ray-traversal value 1 on the shader domain.
- R5: Delegate (opcode 3) requires the domain's allow flag. On success, after SETTLE cycles, the allow flag clears, the delegated flag sets, and delegation-changed (bit 2) is raised. Delegating L2, or a domain whose allow flag is clear, raises command-not-allowed (bit 6). A domain never has both flags set.
- R6: Retract (opcode 4) requires the delegated flag and is refused for L2 with command-not-allowed. While it runs, status bit 16 (retract pending) is set. On completion the delegated flag clears, the allow flag sets, and both retract-completed (bit 4) and delegation-changed (bit 2) are raised.
- R7: A power command to a delegated domain is dropped: the ready mask does not change, and command-not-allowed is raised.
- R8: Soft reset (opcode 5) is accepted only while the `soft_rst_permit` input, mirrored in status bit 17, is high. Otherwise it raises command-not-allowed. An accepted soft reset completes after SETTLE cycles and then does four things: it clears all ready masks, sets every allow flag, clears every delegated flag, and raises reset-completed (bit 3).
- R9: Writing ones to the clear register clears those raw bits. Raw bits stay readable whatever the mask is. `irq` is high exactly when the raw bits ANDed with the mask are nonzero. Register 0x06 reads that AND.
- R10: A command that needs the sequencer and is written while an operation is still in progress raises command-not-allowed and is dropped.
- R11: Every completed power command raises power-changed-single (bit 0). Power-changed-all (bit 1) is also raised when the effective mask covered every present core of the domain. Inspect (opcode 6) raises inspect-completed (bit 5) one cycle after the write and changes no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| soft_rst_permit | input | 1 | Allows the soft reset command |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register word address |
| reg_wdata | input | 64 | Write data |
| reg_rdata | output | 64 | Read data for `reg_addr` (combinational) |
| irq | output | 1 | Interrupt request |

## Verification
A wrong sequencer state shows at the ports as a ready mask that changes too early, too late or never. It also shows as an in-transition mask that is still nonzero after SETTLE cycles. Both are visible within SETTLE+1 cycles of the command write. A wrong ownership state surfaces as a status word in which a domain has both flags or neither. It also surfaces as a command that should have been accepted but raises command-not-allowed on the very next cycle. A wrong interrupt state is seen immediately on `irq` and in the masked-interrupt register.

// File: rtl/pdc_pkg.sv
// Shared constants for the power domain command controller.
// Assumes five domains with fixed codes; opcodes and interrupt bit positions
// are visible to software and must not move.
package pdc_pkg;
    localparam int NDOM = 5;
    localparam int NIRQ = 8;

    localparam logic [3:0] OP_UP      = 4'd1;
    localparam logic [3:0] OP_DOWN    = 4'd2;
    localparam logic [3:0] OP_DELEG   = 4'd3;
    localparam logic [3:0] OP_RETRACT = 4'd4;
    localparam logic [3:0] OP_SRESET  = 4'd5;
    localparam logic [3:0] OP_INSPECT = 4'd6;

    localparam logic [2:0] DOM_L2     = 3'd0;
    localparam logic [2:0] DOM_SHADER = 3'd2;
    localparam logic [3:0] SUB_RAY    = 4'd1;

    localparam int IRQ_SINGLE  = 0;
    localparam int IRQ_ALL     = 1;
    localparam int IRQ_DELEG   = 2;
    localparam int IRQ_RESET   = 3;
    localparam int IRQ_RETRACT = 4;
    localparam int IRQ_INSPECT = 5;
    localparam int IRQ_DENIED  = 6;
    localparam int IRQ_INVALID = 7;

    localparam logic [7:0] A_ARG  = 8'h00;
    localparam logic [7:0] A_CMD  = 8'h01;
    localparam logic [7:0] A_STAT = 8'h02;
    localparam logic [7:0] A_RAW  = 8'h03;
    localparam logic [7:0] A_MASK = 8'h04;
    localparam logic [7:0] A_CLR  = 8'h05;
    localparam logic [7:0] A_PEND = 8'h06;
    localparam int         A_DOM  = 16;
endpackage

// File: rtl/pdc_cmd_check.sv
// Command checker: classifies a written command word as invalid, denied or
// accepted, using the current ownership flags and sequencer state.
// Assumes the command word is presented in the same cycle as its write strobe.
module pdc_cmd_check
    import pdc_pkg::*;
(
    input  logic            cmd_wr,
    input  logic [11:0]     cmd,
    input  logic [NDOM-1:0] allow,
    input  logic [NDOM-1:0] deleg,
    input  logic            busy,
    input  logic            permit,
    output logic [3:0]      op,
    output logic [2:0]      dom,
    output logic            accept,
    output logic            bad_cmd,
    output logic            denied
);
    logic [3:0]      sub;
    logic            op_ok, dom_ok, sub_ok, bad, deny;
    logic            dom_allow, dom_deleg;
    logic [NDOM-1:0] dom_bit;

    // Field extraction and legality of opcode, domain and subdomain
    always_comb begin
        op      = cmd[3:0];
        dom     = cmd[6:4];
        sub     = cmd[11:8];
        op_ok   = (op >= OP_UP) && (op <= OP_INSPECT);
        dom_ok  = ({29'd0, dom} < NDOM);
        sub_ok  = (sub == 4'd0) || (sub == SUB_RAY && dom == DOM_SHADER);
        bad     = !(op_ok && dom_ok && sub_ok);
        dom_bit = dom_ok ? (NDOM'(1) << dom) : '0;
        dom_allow = |(allow & dom_bit);
        dom_deleg = |(deleg & dom_bit);
    end

    // Permission rules per opcode
    always_comb begin
        unique case (op)
            OP_UP, OP_DOWN: deny = busy || dom_deleg || !dom_allow;
            OP_DELEG:       deny = busy || dom == DOM_L2 || !dom_allow;
            OP_RETRACT:     deny = busy || dom == DOM_L2 || !dom_deleg;
            OP_SRESET:      deny = busy || !permit;
            default:        deny = 1'b0;
        endcase
    end

    // Outcome strobes, qualified by the write
    always_comb begin
        bad_cmd = cmd_wr && bad;
        denied  = cmd_wr && !bad && deny;
        accept  = cmd_wr && !bad && !deny;
    end
endmodule

// File: rtl/pdc_domain.sv
// One power domain: holds the ready and in-transition core masks.
// Assumes start and done are never high together and that eff is already
// restricted to present cores.
module pdc_domain #(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic          up,
    input  logic [CW-1:0] eff,
    input  logic          done,
    input  logic          wipe,
    output logic [CW-1:0] ready,
    output logic [CW-1:0] trans
);
    logic dir_up;

    // Latch the transition at start, apply it to the ready mask at done
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ready  <= '0;
            trans  <= '0;
            dir_up <= 1'b0;
        end else if (wipe) begin
            ready  <= '0;
            trans  <= '0;
        end else if (start) begin
            trans  <= eff;
            dir_up <= up;
        end else if (done) begin
            ready  <= dir_up ? (ready | trans) : (ready & ~trans);
            trans  <= '0;
        end
    end
endmodule

// File: rtl/pdc_irq.sv
// Interrupt block: raw sticky bits, mask, write-one-to-clear.
// Assumes a set and a clear of the same bit in one cycle leaves it set.
module pdc_irq #(
    parameter int N = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set,
    input  logic         clr_wr,
    input  logic         mask_wr,
    input  logic [N-1:0] wdata,
    output logic [N-1:0] raw,
    output logic [N-1:0] mask,
    output logic         irq
);
    // Raw and mask register update
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            raw  <= '0;
            mask <= '0;
        end else begin
            raw <= (raw & ~(clr_wr ? wdata : '0)) | set;
            if (mask_wr) mask <= wdata;
        end
    end

    // Request line from enabled pending sources
    always_comb irq = |(raw & mask);
endmodule

// File: rtl/pwr_domain_ctrl.sv
// Power domain command controller top: register file, command sequencer,
// ownership flags, per-domain core masks and interrupts.
// Assumes a single register port with combinational reads; one timed
// operation runs at a time, lasting SETTLE cycles (SETTLE >= 1).
module pwr_domain_ctrl
    import pdc_pkg::*;
#(
    parameter int                 CW      = 8,
    parameter int                 SETTLE  = 4,
    parameter logic [NDOM*CW-1:0] PRESENT = {8'h03, 8'h03, 8'h0F, 8'h01, 8'h01}
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        soft_rst_permit,
    input  logic        reg_wr,
    input  logic [7:0]  reg_addr,
    input  logic [63:0] reg_wdata,
    output logic [63:0] reg_rdata,
    output logic        irq
);
    localparam int CNTW = $clog2(SETTLE + 1);

    logic [63:0]      arg_q;
    logic [NDOM-1:0]  allow_q, deleg_q;
    logic             busy_q, all_q;
    logic [CNTW-1:0]  cnt_q;
    logic [3:0]       op_q, op_w;
    logic [2:0]       dom_q, dom_w;
    logic             accept, bad_cmd, denied, done, is_pwr_w, is_pwr_q;
    logic             rpend;
    logic [NDOM*CW-1:0] ready_all, trans_all;
    logic [NIRQ-1:0]  irq_set, irq_raw, irq_mask;
    logic [CW-1:0]    eff_sel;
    logic             unused_bits;

    assign unused_bits = ^{reg_wdata[63:12], arg_q[63:CW]};

    pdc_cmd_check u_check (
        .cmd_wr (reg_wr && reg_addr == A_CMD),
        .cmd    (reg_wdata[11:0]),
        .allow  (allow_q),
        .deleg  (deleg_q),
        .busy   (busy_q),
        .permit (soft_rst_permit),
        .op     (op_w),
        .dom    (dom_w),
        .accept (accept),
        .bad_cmd(bad_cmd),
        .denied (denied)
    );

    // Decode helpers for the incoming and the running operation
    always_comb begin
        is_pwr_w = (op_w == OP_UP) || (op_w == OP_DOWN);
        is_pwr_q = (op_q == OP_UP) || (op_q == OP_DOWN);
        done     = busy_q && (cnt_q == CNTW'(1));
        rpend    = busy_q && (op_q == OP_RETRACT);
        eff_sel  = '0;
        for (int d = 0; d < NDOM; d++)
            if (dom_w == 3'(d)) eff_sel = arg_q[CW-1:0] & PRESENT[d*CW +: CW];
    end

    // Argument register
    always_ff @(posedge clk) begin
        if (!rst_n)                            arg_q <= '0;
        else if (reg_wr && reg_addr == A_ARG)  arg_q <= reg_wdata;
    end

    // Sequencer: loads on an accepted timed command, counts down to done
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
            cnt_q  <= '0;
            op_q   <= '0;
            dom_q  <= '0;
            all_q  <= 1'b0;
        end else if (accept && op_w != OP_INSPECT) begin
            busy_q <= 1'b1;
            cnt_q  <= CNTW'(SETTLE);
            op_q   <= op_w;
            dom_q  <= dom_w;
            all_q  <= 1'b0;
            for (int d = 0; d < NDOM; d++)
                if (dom_w == 3'(d)) all_q <= (eff_sel == PRESENT[d*CW +: CW]);
        end else if (busy_q) begin
            cnt_q <= cnt_q - CNTW'(1);
            if (done) busy_q <= 1'b0;
        end
    end

    // Ownership flags: swap on hand-over completion, restore on soft reset
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            allow_q <= '1;
            deleg_q <= '0;
        end else if (done) begin
            for (int d = 0; d < NDOM; d++) begin
                if (dom_q == 3'(d) && op_q == OP_DELEG) begin
                    allow_q[d] <= 1'b0;
                    deleg_q[d] <= 1'b1;
                end
                if (dom_q == 3'(d) && op_q == OP_RETRACT) begin
                    allow_q[d] <= 1'b1;
                    deleg_q[d] <= 1'b0;
                end
            end
            if (op_q == OP_SRESET) begin
                allow_q <= '1;
                deleg_q <= '0;
            end
        end
    end

    for (genvar d = 0; d < NDOM; d++) begin : g_dom
        pdc_domain #(.CW(CW)) u_dom (
            .clk  (clk),
            .rst_n(rst_n),
            .start(accept && is_pwr_w && dom_w == 3'(d)),
            .up   (op_w == OP_UP),
            .eff  (arg_q[CW-1:0] & PRESENT[d*CW +: CW]),
            .done (done && is_pwr_q && dom_q == 3'(d)),
            .wipe (done && op_q == OP_SRESET),
            .ready(ready_all[d*CW +: CW]),
            .trans(trans_all[d*CW +: CW])
        );
    end

    // Interrupt source strobes
    always_comb begin
        irq_set              = '0;
        irq_set[IRQ_SINGLE]  = done && is_pwr_q;
        irq_set[IRQ_ALL]     = done && is_pwr_q && all_q;
        irq_set[IRQ_DELEG]   = done && (op_q == OP_DELEG || op_q == OP_RETRACT);
        irq_set[IRQ_RESET]   = done && op_q == OP_SRESET;
        irq_set[IRQ_RETRACT] = done && op_q == OP_RETRACT;
        irq_set[IRQ_INSPECT] = accept && op_w == OP_INSPECT;
        irq_set[IRQ_DENIED]  = denied;
        irq_set[IRQ_INVALID] = bad_cmd;
    end

    pdc_irq #(.N(NIRQ)) u_irq (
        .clk    (clk),
        .rst_n  (rst_n),
        .set    (irq_set),
        .clr_wr (reg_wr && reg_addr == A_CLR),
        .mask_wr(reg_wr && reg_addr == A_MASK),
        .wdata  (reg_wdata[NIRQ-1:0]),
        .raw    (irq_raw),
        .mask   (irq_mask),
        .irq    (irq)
    );

    // Read multiplexer
    always_comb begin
        reg_rdata = '0;
        unique case (reg_addr)
            A_ARG:  reg_rdata = arg_q;
            A_STAT: begin
                reg_rdata[NDOM-1:0]  = allow_q;
                reg_rdata[8 +: NDOM] = deleg_q;
                reg_rdata[16]        = rpend;
                reg_rdata[17]        = soft_rst_permit;
            end
            A_RAW:  reg_rdata = 64'(irq_raw);
            A_MASK: reg_rdata = 64'(irq_mask);
            A_PEND: reg_rdata = 64'(irq_raw & irq_mask);
            default: begin
                for (int d = 0; d < NDOM; d++) begin
                    if (reg_addr == 8'(A_DOM + 4*d))     reg_rdata = 64'(PRESENT[d*CW +: CW]);
                    if (reg_addr == 8'(A_DOM + 4*d + 1)) reg_rdata = 64'(ready_all[d*CW +: CW]);
                    if (reg_addr == 8'(A_DOM + 4*d + 2)) reg_rdata = 64'(trans_all[d*CW +: CW]);
                end
            end
        endcase
    end
endmodule

// File: rtl/pdc_checker.sv
// Property checker for pwr_domain_ctrl, attached by bind.
// Assumes the default domain codes and interrupt bit positions of pdc_pkg.
module pdc_checker
    import pdc_pkg::*;
#(
    parameter int                 CW      = 8,
    parameter logic [NDOM*CW-1:0] PRESENT = '0
) (
    input logic               clk,
    input logic               rst_n,
    input logic [NDOM-1:0]    allow,
    input logic [NDOM-1:0]    deleg,
    input logic               busy,
    input logic               rpend,
    input logic [NDOM*CW-1:0] ready_all,
    input logic [NIRQ-1:0]    irq_raw,
    input logic               reg_wr,
    input logic [7:0]         reg_addr,
    input logic [63:0]        reg_wdata
);
    // R5
    flags_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (allow & deleg) == '0);

    // R5
    l2_host_owned_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !deleg[0]);

    // R6
    retract_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rpend |=> (rpend || irq_raw[IRQ_RETRACT]));

    // R2
    ready_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |=> $stable(ready_all));

    // R3
    ready_present_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ready_all & ~PRESENT) == '0);

    // R4
    bad_opcode_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == A_CMD && reg_wdata[3:0] == 4'd0) |=> irq_raw[IRQ_INVALID]);

    // R10
    busy_reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && reg_wr && reg_addr == A_CMD && reg_wdata[11:0] == 12'h001)
        |=> irq_raw[IRQ_DENIED]);
endmodule

bind pwr_domain_ctrl pdc_checker #(.CW(CW), .PRESENT(PRESENT)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .allow    (allow_q),
    .deleg    (deleg_q),
    .busy     (busy_q),
    .rpend    (rpend),
    .ready_all(ready_all),
    .irq_raw  (irq_raw),
    .reg_wr   (reg_wr),
    .reg_addr (reg_addr),
    .reg_wdata(reg_wdata)
);

// File: tb/pwr_domain_ctrl_tb.sv
// Self-checking bench: a vector table walked by one loop, then directed tests.
module pwr_domain_ctrl_tb;
    localparam int SETTLE = 4;
    localparam int NV     = 15;

    typedef struct packed {
        logic [63:0] arg;
        logic [31:0] cmd;
        logic [7:0]  addr;
        logic [63:0] exp;
        logic [7:0]  irq;
        logic [23:0] tag;
    } vec_t;

    localparam vec_t VEC [NV] = '{
        '{64'h1,                   32'h001, 8'h11, 64'h1,   8'h03, "R2"},
        '{64'h5,                   32'h021, 8'h19, 64'h5,   8'h01, "R2"},
        '{64'hFFFF_FFFF_FFFF_FF0A, 32'h021, 8'h19, 64'hF,   8'h01, "R3"},
        '{64'hF,                   32'h122, 8'h19, 64'h0,   8'h03, "R4"},
        '{64'h1,                   32'h111, 8'h15, 64'h0,   8'h80, "R4"},
        '{64'h0,                   32'h000, 8'h02, 64'h1F,  8'h80, "R4"},
        '{64'h1,                   32'h051, 8'h02, 64'h1F,  8'h80, "R4"},
        '{64'h0,                   32'h023, 8'h02, 64'h41B, 8'h04, "R5"},
        '{64'hF,                   32'h021, 8'h19, 64'h0,   8'h40, "R7"},
        '{64'h0,                   32'h003, 8'h02, 64'h41B, 8'h40, "R5"},
        '{64'h0,                   32'h023, 8'h02, 64'h41B, 8'h40, "R5"},
        '{64'h0,                   32'h014, 8'h02, 64'h41B, 8'h40, "R6"},
        '{64'h0,                   32'h024, 8'h02, 64'h1F,  8'h14, "R6"},
        '{64'h0,                   32'h006, 8'h02, 64'h1F,  8'h20, "R11"},
        '{64'h0,                   32'h005, 8'h11, 64'h1,   8'h40, "R8"}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        soft_rst_permit = 1'b0;
    logic        reg_wr = 1'b0;
    logic [7:0]  reg_addr = '0;
    logic [63:0] reg_wdata = '0;
    logic [63:0] reg_rdata;
    logic        irq;
    int          checks = 0;
    int          errors = 0;
    logic [63:0] v;

    always #4 clk = ~clk;

    pwr_domain_ctrl #(.SETTLE(SETTLE)) u_dut (
        .clk(clk), .rst_n(rst_n), .soft_rst_permit(soft_rst_permit),
        .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .irq(irq)
    );

    task automatic wr(input logic [7:0] a, input logic [63:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [63:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic chk(input logic [23:0] tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic settle();
        repeat (SETTLE + 2) @(negedge clk);
    endtask

    initial begin
        #(8 * 100000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        rd(8'h02, v); chk("R1", v, 64'h1F);
        rd(8'h03, v); chk("R1", v, 64'h0);
        rd(8'h04, v); chk("R1", v, 64'h0);
        rd(8'h19, v); chk("R1", v, 64'h0);
        rd(8'h1A, v); chk("R1", v, 64'h0);
        rd(8'h18, v); chk("R3", v, 64'hF);
        chk("R1", 64'(irq), 64'h0);

        for (int i = 0; i < NV; i++) begin
            wr(8'h05, 64'hFF);
            wr(8'h00, VEC[i].arg);
            wr(8'h01, 64'(VEC[i].cmd));
            settle();
            rd(VEC[i].addr, v); chk(VEC[i].tag, v, VEC[i].exp);
            rd(8'h03, v);       chk(VEC[i].tag, v, 64'(VEC[i].irq));
        end

        // R2 settle timing on an L2 power-down
        wr(8'h05, 64'hFF);
        wr(8'h00, 64'h1);
        wr(8'h01, 64'h002);
        repeat (SETTLE - 1) @(negedge clk);
        rd(8'h12, v); chk("R2", v, 64'h1);
        rd(8'h11, v); chk("R2", v, 64'h1);
        @(negedge clk);
        rd(8'h11, v); chk("R2", v, 64'h0);
        rd(8'h12, v); chk("R2", v, 64'h0);
        wr(8'h01, 64'h001);
        settle();

        // R10 command while busy is dropped
        wr(8'h05, 64'hFF);
        wr(8'h00, 64'h3);
        wr(8'h01, 64'h041);
        wr(8'h01, 64'h011);
        settle();
        rd(8'h15, v); chk("R10", v, 64'h0);
        rd(8'h21, v); chk("R10", v, 64'h3);
        rd(8'h03, v); chk("R10", v, 64'h43);

        // R6 retract pending visible while running
        wr(8'h01, 64'h033);
        settle();
        wr(8'h05, 64'hFF);
        wr(8'h01, 64'h034);
        rd(8'h02, v); chk("R6", v, 64'h10817);
        settle();
        rd(8'h02, v); chk("R6", v, 64'h1F);

        // R9 mask, masked view and clear
        wr(8'h05, 64'hFF);
        wr(8'h01, 64'h000);
        settle();
        rd(8'h03, v); chk("R9", v, 64'h80);
        chk("R9", 64'(irq), 64'h0);
        wr(8'h04, 64'h80);
        chk("R9", 64'(irq), 64'h1);
        rd(8'h06, v); chk("R9", v, 64'h80);
        wr(8'h05, 64'h80);
        chk("R9", 64'(irq), 64'h0);
        rd(8'h03, v); chk("R9", v, 64'h0);
        wr(8'h04, 64'h0);

        // R8 permitted soft reset
        soft_rst_permit = 1'b1;
        wr(8'h01, 64'h023);
        settle();
        wr(8'h05, 64'hFF);
        wr(8'h01, 64'h005);
        settle();
        rd(8'h11, v); chk("R8", v, 64'h0);
        rd(8'h21, v); chk("R8", v, 64'h0);
        rd(8'h03, v); chk("R8", v, 64'h08);
        rd(8'h02, v); chk("R8", v, 64'h2001F);

        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule